// File: doc/BRIEF.md
# Packed sample input register pair

This block holds the parallel sample input for one even/odd pair of filter channels. A bus master, either a CPU or a memory-to-peripheral DMA writer, writes a 32-bit word into either channel's data register. Two half-word enables mark the access as 16-bit (low half only) or 32-bit (both halves). A downstream filter drains each channel one 16-bit sample at a time through a valid/data/take handshake. Each channel also raises an empty flag, which serves as a DMA request for the next word. This input path is independent of any result path, so both can be serviced in the same cycle.

A 2-bit packing mode per channel decides how the halves of a write become samples. In single mode only the low half is kept. In paired mode one channel buffers two samples, and the low half is delivered before the high half. In split mode, on the even channel only, the low half feeds the even channel and the high half is forwarded into the odd channel's register. Split mode selected on the odd channel protects that register against every write.

A write aimed at a register that still holds samples is dropped and sets a sticky overrun flag for that channel. A take that empties a register in the same cycle as a write makes room for that write.

Top module: `pkdin_pair`

## Requirements
- R1: After reset both channels report empty, neither presents a valid sample, neither overrun flag is set, and both modes behave as if configured to code 0.
- R2: With mode code 0 (single) or code 3 (reserved, same behaviour), a write with the low half enabled (bus_hen bit 0 = lanes [15:0]) stores exactly one sample equal to wdata[15:0]. The high half (bus_hen bit 1 = lanes [31:16]) is discarded.
- R3: With mode code 1 (paired), a 32-bit write (bus_hen = 2'b11) queues two samples: wdata[15:0] is presented first and wdata[31:16] second. A 16-bit write (bus_hen = 2'b01) queues only wdata[15:0].
- R4: With mode code 2 (split) on the even channel (bus_sel = 0), wdata[15:0] becomes one even-channel sample and wdata[31:16] becomes one odd-channel sample, whatever the odd channel's mode. Each channel then needs one take to empty.
- R5: With mode code 2 on the odd channel, a write with bus_sel = 1 changes nothing: the channel stays as it was and no overrun is raised.
- R6: In modes 0, 1 and 3, a write that enables only the high half (bus_hen = 2'b10) has no effect on the addressed channel.
- R7: A channel's empty flag is high exactly when it holds no pending sample. It goes low in the cycle after a write to that channel is accepted.
- R8: Valid and data stay constant until the filter pulses take for that channel. A take while the channel is empty has no effect.
- R9: A write, including a forwarded half, whose target register still holds a sample after this cycle's take is dropped. The stored samples are kept unchanged, and that channel's overrun flag is set and stays set until reset.
- R10: When a take removes a channel's last sample in the same cycle as a write to it, the take is served first and the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode_even | input | 2 | Packing mode of the even channel (0 single, 1 paired, 2 split, 3 reserved) |
| cfg_mode_odd | input | 2 | Packing mode of the odd channel |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_sel | input | 1 | Target register: 0 even, 1 odd |
| bus_hen | input | 2 | Half-word enables: bit 0 lanes [15:0], bit 1 lanes [31:16] |
| bus_wdata | input | 2*SW | Write data |
| flt_take | input | 2 | Per-channel read strobe from the filter (bit 0 even) |
| flt_valid | output | 2 | Per-channel sample valid |
| flt_data_even | output | SW | Even channel's current sample |
| flt_data_odd | output | SW | Odd channel's current sample |
| dreq_empty | output | 2 | Per-channel empty flag / DMA request |
| ovr_flag | output | 2 | Per-channel sticky overrun |

## Verification
The bench targets the orderings that are easy to get wrong. If paired-mode halves are swapped, the high sample shows up first. If split mode drops the forwarded half, the odd channel never becomes valid, and if split mode also loads the odd channel when it is selected directly, R5 breaks. A design that tests emptiness before subtracting the same-cycle take drops the write in R10 and raises a false overrun. A design that overwrites a full register instead of keeping its contents changes the presented sample in R9. A constrained-random phase mixes every mode, every enable pattern and concurrent takes to expose any interaction between forwarding and overrun.

// File: rtl/pkdin_pkg.sv
package pkdin_pkg;

  typedef enum logic [1:0] {
    PK_SINGLE = 2'd0,
    PK_PAIR   = 2'd1,
    PK_SPLIT  = 2'd2,
    PK_RSVD   = 2'd3
  } pack_mode_e;

  // Number of samples a write places into the addressed channel itself.
  function automatic logic [1:0] own_count(input logic [1:0] mode,
                                           input logic lo_en,
                                           input logic hi_en,
                                           input logic is_odd);
    logic [1:0] n;
    case (pack_mode_e'(mode))
      PK_PAIR:  n = lo_en ? (hi_en ? 2'd2 : 2'd1) : 2'd0;
      PK_SPLIT: n = (is_odd || !lo_en) ? 2'd0 : 2'd1;
      default:  n = lo_en ? 2'd1 : 2'd0;
    endcase
    return n;
  endfunction

  // True when the high half of a write must be forwarded to the odd neighbour.
  function automatic logic forward_hi(input logic [1:0] mode,
                                      input logic hi_en,
                                      input logic is_odd);
    return (pack_mode_e'(mode) == PK_SPLIT) && !is_odd && hi_en;
  endfunction

endpackage

// File: rtl/pkdin_wr_decode.sv
module pkdin_wr_decode
  import pkdin_pkg::*;
#(
  parameter int SW  = 16,
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode_even,
  input  logic [1:0]              mode_odd,
  input  logic                    wr,
  input  logic                    sel,
  input  logic [1:0]              hen,
  input  logic [2*SW-1:0]         wdata,
  output logic [NCH-1:0]          ld_req,
  output logic [NCH-1:0]          ld_two,
  output logic [NCH-1:0][SW-1:0]  ld_lo,
  output logic [NCH-1:0][SW-1:0]  ld_hi
);

  logic [SW-1:0] w_lo, w_hi;
  logic [1:0]    mode_sel;
  logic [1:0]    n_own;
  logic          fwd_ev;
  logic          prot_ev;

  assign w_lo     = wdata[SW-1:0];
  assign w_hi     = wdata[2*SW-1:SW];
  assign mode_sel = sel ? mode_odd : mode_even;
  assign n_own    = wr ? own_count(mode_sel, hen[0], hen[1], sel) : 2'd0;
  assign fwd_ev   = wr && forward_hi(mode_sel, hen[1], sel);
  assign prot_ev  = wr && (n_own == 2'd0) && !fwd_ev;

  always_comb begin
    ld_req = '0;
    ld_two = '0;
    ld_lo  = '0;
    ld_hi  = '0;
    if (!sel && n_own != 2'd0) begin
      ld_req[0] = 1'b1;
      ld_two[0] = (n_own == 2'd2);
      ld_lo[0]  = w_lo;
      ld_hi[0]  = w_hi;
    end
    if (sel && n_own != 2'd0) begin
      ld_req[1] = 1'b1;
      ld_two[1] = (n_own == 2'd2);
      ld_lo[1]  = w_lo;
      ld_hi[1]  = w_hi;
    end
    if (fwd_ev) begin
      ld_req[1] = 1'b1;
      ld_two[1] = 1'b0;
      ld_lo[1]  = w_hi;
    end
  end

  // R5: odd channel in split mode never loads from its own write
  a_r5_odd_split_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel && mode_odd == 2'd2) |-> (ld_req == '0));

  // R4: split write on even channel hands the high half to the odd register
  a_r4_forward_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !sel && mode_even == 2'd2 && hen[1]) |-> (ld_req[1] && ld_lo[1] == wdata[2*SW-1:SW]));

  // R6: high-only write outside split mode loads nothing
  a_r6_hi_only_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hen == 2'b10 && mode_sel != 2'd2) |-> (ld_req == '0));

  // R6: a fully protected write produces no load request
  a_r6_protected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    prot_ev |-> (ld_req == '0));

endmodule

// File: rtl/pkdin_chan.sv
module pkdin_chan #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_req,
  input  logic          ld_two,
  input  logic [SW-1:0] ld_lo,
  input  logic [SW-1:0] ld_hi,
  input  logic          take,
  output logic          valid,
  output logic [SW-1:0] data,
  output logic          empty,
  output logic          ovr
);

  logic [1:0]    cnt;
  logic          ptr;
  logic [SW-1:0] lo_q, hi_q;
  logic          ovr_q;

  logic          take_fire;
  logic [1:0]    cnt_after;
  logic          room;
  logic          ld_accept;
  logic          ld_drop;

  assign take_fire = take && (cnt != 2'd0);
  assign cnt_after = cnt - {1'b0, take_fire};
  assign room      = (cnt_after == 2'd0);
  assign ld_accept = ld_req && room;
  assign ld_drop   = ld_req && !room;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= 2'd0;
      ptr   <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (ld_accept) begin
        cnt  <= ld_two ? 2'd2 : 2'd1;
        ptr  <= 1'b0;
        lo_q <= ld_lo;
        hi_q <= ld_hi;
      end else if (take_fire) begin
        cnt <= cnt_after;
        ptr <= 1'b1;
      end
      if (ld_drop) ovr_q <= 1'b1;
    end
  end

  assign valid = (cnt != 2'd0);
  assign empty = (cnt == 2'd0);
  assign data  = ptr ? hi_q : lo_q;
  assign ovr   = ovr_q;

  // R3: at most two samples are ever pending
  a_r3_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != 2'd3);

  // R3: after the first of two samples is taken the stored high half follows
  a_r3_high_second: assert property (@(posedge clk) disable iff (!rst_n)
    (take_fire && cnt == 2'd2) |=> (valid && data == $past(hi_q)));

  // R7: an accepted write clears the empty flag on the next cycle
  a_r7_empty_falls: assert property (@(posedge clk) disable iff (!rst_n)
    ld_accept |=> !empty);

  // R8: without a take the presented sample does not move
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !take) |=> (valid && $stable(data)));

  // R9: a dropped write raises overrun
  a_r9_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ld_drop |=> ovr);

  // R9: overrun is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);

  // R10: a take that drains the last sample makes room for a same-cycle write
  a_r10_take_first: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt == 2'd1 && ld_req) |-> ld_accept);

endmodule

// File: rtl/pkdin_pair.sv
module pkdin_pair
  import pkdin_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_mode_even,
  input  logic [1:0]      cfg_mode_odd,
  input  logic            bus_wr,
  input  logic            bus_sel,
  input  logic [1:0]      bus_hen,
  input  logic [2*SW-1:0] bus_wdata,
  input  logic [1:0]      flt_take,
  output logic [1:0]      flt_valid,
  output logic [SW-1:0]   flt_data_even,
  output logic [SW-1:0]   flt_data_odd,
  output logic [1:0]      dreq_empty,
  output logic [1:0]      ovr_flag
);

  localparam int NCH = 2;

  logic [NCH-1:0]         ld_req, ld_two;
  logic [NCH-1:0][SW-1:0] ld_lo, ld_hi;
  logic [NCH-1:0][SW-1:0] ch_data;

  pkdin_wr_decode #(.SW(SW), .NCH(NCH)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_even (cfg_mode_even),
    .mode_odd  (cfg_mode_odd),
    .wr        (bus_wr),
    .sel       (bus_sel),
    .hen       (bus_hen),
    .wdata     (bus_wdata),
    .ld_req    (ld_req),
    .ld_two    (ld_two),
    .ld_lo     (ld_lo),
    .ld_hi     (ld_hi)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pkdin_chan #(.SW(SW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_req (ld_req[c]),
      .ld_two (ld_two[c]),
      .ld_lo  (ld_lo[c]),
      .ld_hi  (ld_hi[c]),
      .take   (flt_take[c]),
      .valid  (flt_valid[c]),
      .data   (ch_data[c]),
      .empty  (dreq_empty[c]),
      .ovr    (ovr_flag[c])
    );
  end

  assign flt_data_even = ch_data[0];
  assign flt_data_odd  = ch_data[1];

  // R1: in the cycle after reset nothing is pending and no overrun is shown
  a_r1_reset_state: assert property (@(posedge clk)
    $past(!rst_n) |-> (dreq_empty == 2'b11 && flt_valid == 2'b00 && ovr_flag == 2'b00));

  // R7: empty and valid are never both set on a channel
  a_r7_empty_vs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid & dreq_empty) == 2'b00);

endmodule

// File: tb/pkdin_pair_tb.sv
module pkdin_pair_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_e = 2'd0, mode_o = 2'd0;
  logic        wr = 1'b0, sel = 1'b0;
  logic [1:0]  hen = 2'b00;
  logic [31:0] wdata = '0;
  logic [1:0]  take = 2'b00;
  logic [1:0]  valid, empty, ovr;
  logic [15:0] d_e, d_o;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit started = 0;

  int q_e[$], q_o[$];
  logic [1:0] m_ovr;

  always #2.5 clk = ~clk;

  pkdin_pair #(.SW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode_even(mode_e), .cfg_mode_odd(mode_o),
    .bus_wr(wr), .bus_sel(sel), .bus_hen(hen), .bus_wdata(wdata),
    .flt_take(take), .flt_valid(valid), .flt_data_even(d_e), .flt_data_odd(d_o),
    .dreq_empty(empty), .ovr_flag(ovr)
  );

  // Behavioural reference model: queues of pending samples per channel.
  always @(posedge clk) begin
    int own[$];
    int fw[$];
    int lo, hi;
    logic [1:0] m;
    own.delete();
    fw.delete();
    if (!rst_n) begin
      q_e.delete();
      q_o.delete();
      m_ovr = 2'b00;
    end else begin
      if (take[0] && q_e.size() > 0) void'(q_e.pop_front());
      if (take[1] && q_o.size() > 0) void'(q_o.pop_front());
      if (wr) begin
        lo = int'(wdata[15:0]);
        hi = int'(wdata[31:16]);
        m  = sel ? mode_o : mode_e;
        if (m == 2'd2) begin
          if (!sel) begin
            if (hen[0]) own.push_back(lo);
            if (hen[1]) fw.push_back(hi);
          end
        end else if (m == 2'd1) begin
          if (hen[0]) begin
            own.push_back(lo);
            if (hen[1]) own.push_back(hi);
          end
        end else if (hen[0]) begin
          own.push_back(lo);
        end
        if (own.size() > 0) begin
          if (!sel) begin
            if (q_e.size() == 0) q_e = own; else m_ovr[0] = 1'b1;
          end else begin
            if (q_o.size() == 0) q_o = own; else m_ovr[1] = 1'b1;
          end
        end
        if (fw.size() > 0) begin
          if (q_o.size() == 0) q_o = fw; else m_ovr[1] = 1'b1;
        end
      end
      started = 1;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (started && rst_n) begin
      chk("valid_e", int'(valid[0]), int'(q_e.size() > 0));
      chk("valid_o", int'(valid[1]), int'(q_o.size() > 0));
      chk("empty_e", int'(empty[0]), int'(q_e.size() == 0));
      chk("empty_o", int'(empty[1]), int'(q_o.size() == 0));
      chk("ovr",     int'(ovr),      int'(m_ovr));
      if (q_e.size() > 0) chk("data_e", int'(d_e), q_e[0] & 16'hFFFF);
      if (q_o.size() > 0) chk("data_o", int'(d_o), q_o[0] & 16'hFFFF);
    end
  end

  task automatic op(input logic w, input logic s, input logic [1:0] h,
                    input logic [31:0] d, input logic [1:0] t);
    @(negedge clk);
    wr = w; sel = s; hen = h; wdata = d; take = t;
    @(negedge clk);
    wr = 1'b0; take = 2'b00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty", int'(empty), 3);
    chk("R1 valid", int'(valid), 0);
    chk("R1 ovr", int'(ovr), 0);
    op(1, 0, 2'b11, 32'hBEEF_0101, 2'b00);
    chk("R1 default mode single", int'(d_e), 16'h0101);
    op(0, 0, 2'b00, 0, 2'b01);

    // R2: single and reserved modes keep the low half only
    cur_req = "R2";
    op(1, 0, 2'b11, 32'hAAAA_1111, 2'b00);
    chk("R2 low half", int'(d_e), 16'h1111);
    op(0, 0, 2'b00, 0, 2'b01);
    chk("R2 one take empties", int'(empty[0]), 1);
    mode_o = 2'd3;
    op(1, 1, 2'b11, 32'hCCCC_2222, 2'b00);
    chk("R2 reserved low", int'(d_o), 16'h2222);
    op(0, 0, 2'b00, 0, 2'b10);
    chk("R2 reserved empties", int'(empty[1]), 1);

    // R3: paired mode, low then high
    cur_req = "R3";
    mode_e = 2'd1; mode_o = 2'd0;
    op(1, 0, 2'b11, 32'h3333_4444, 2'b00);
    chk("R3 first low", int'(d_e), 16'h4444);
    op(0, 0, 2'b00, 0, 2'b01);
    chk("R3 second high", int'(d_e), 16'h3333);
    op(0, 0, 2'b00, 0, 2'b01);
    chk("R3 empty after two", int'(empty[0]), 1);
    op(1, 0, 2'b01, 32'h9999_5555, 2'b00);
    op(0, 0, 2'b00, 0, 2'b01);
    chk("R3 16-bit one sample", int'(empty[0]), 1);

    // R4: split mode forwards the high half
    cur_req = "R4";
    mode_e = 2'd2; mode_o = 2'd0;
    op(1, 0, 2'b11, 32'h6666_7777, 2'b00);
    chk("R4 even low", int'(d_e), 16'h7777);
    chk("R4 odd gets high", int'(d_o), 16'h6666);
    op(0, 0, 2'b00, 0, 2'b11);
    chk("R4 both empty", int'(empty), 3);

    // R5: split on odd protects both halves
    cur_req = "R5";
    mode_o = 2'd2;
    op(1, 1, 2'b11, 32'h1234_5678, 2'b00);
    chk("R5 odd untouched", int'(empty[1]), 1);
    chk("R5 no overrun", int'(ovr[1]), 0);
    mode_o = 2'd0;

    // R6: high-only write ignored
    cur_req = "R6";
    mode_e = 2'd1;
    op(1, 0, 2'b10, 32'hDEAD_0000, 2'b00);
    chk("R6 paired hi-only", int'(empty[0]), 1);
    mode_e = 2'd0;
    op(1, 0, 2'b10, 32'hDEAD_0000, 2'b00);
    chk("R6 single hi-only", int'(empty[0]), 1);

    // R7 / R8: empty flag timing and hold, take on empty ignored
    cur_req = "R8";
    op(0, 0, 2'b00, 0, 2'b11);
    chk("R8 take on empty", int'(valid), 0);
    cur_req = "R7";
    @(negedge clk);
    wr = 1; sel = 0; hen = 2'b01; wdata = 32'h0000_0ABC;
    chk("R7 empty before edge", int'(empty[0]), 1);
    @(negedge clk);
    wr = 0;
    chk("R7 empty low after write", int'(empty[0]), 0);
    cur_req = "R8";
    idle(3);
    chk("R8 held", int'(d_e), 16'h0ABC);

    // R9: write to full register dropped
    cur_req = "R9";
    op(1, 0, 2'b01, 32'h0000_0DEF, 2'b00);
    chk("R9 contents kept", int'(d_e), 16'h0ABC);
    chk("R9 overrun even", int'(ovr[0]), 1);
    mode_e = 2'd2;
    op(1, 1, 2'b01, 32'h0000_0111, 2'b00);
    op(0, 0, 2'b00, 0, 2'b01);
    op(1, 0, 2'b11, 32'h0222_0333, 2'b00);
    chk("R9 forwarded dropped", int'(d_o), 16'h0111);
    chk("R9 overrun odd", int'(ovr[1]), 1);
    op(0, 0, 2'b00, 0, 2'b11);

    // R10: take drains last sample and same-cycle write accepted
    cur_req = "R10";
    mode_e = 2'd1;
    op(1, 0, 2'b11, 32'h0B0B_0A0A, 2'b00);
    op(1, 0, 2'b01, 32'h0000_0C0C, 2'b01);
    chk("R10 not yet room", int'(d_e), 16'h0B0B);
    op(1, 0, 2'b01, 32'h0000_0D0D, 2'b01);
    chk("R10 accepted", int'(d_e), 16'h0D0D);
    op(0, 0, 2'b00, 0, 2'b01);

    // Mixed traffic against the model
    cur_req = "R9";
    for (int i = 0; i < 300; i++) begin
      mode_e = 2'($urandom_range(0, 3));
      mode_o = 2'($urandom_range(0, 3));
      op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
         2'($urandom_range(0, 3)), $urandom, 2'($urandom_range(0, 3)));
    end
    idle(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule